// File: doc/BRIEF.md
# Single-Line Slave Bit-Slot Engine

This block is the physical bit layer of a slave device that shares one open-drain data line with a host. It watches a synchronized copy of the line and classifies each low period. A low that lasts long enough is a bus reset, and the block answers it with a presence pulse. A short host strobe opens a bit slot. In a write slot the block samples the line and hands the received bit upward. In a read slot it sends a bit that the upper layer supplied, by pulling the line low for a 0 or leaving it released for a 1.

The command layer above sees a small bit-level handshake. It holds `tx_mode` high before a slot begins when it expects the host to read, and keeps `tx_bit` valid at that time. The engine answers with a one-cycle `tx_taken` pulse for a read slot, or with a one-cycle `rx_valid` and `rx_bit` for a write slot. It answers with a one-cycle `bus_reset` pulse when it detects a reset. The block never drives the line high. Its only output to the wire is an active-high pull-down enable. All timing is set in microseconds and scaled by the `CLK_PER_US` parameter.

Top module: `single_line_slave_phy`

## Requirements
- R1: While `rst` is high (synchronous, active high), `pull_low`, `rx_valid`, `tx_taken` and `bus_reset` are 0 from the next clock edge on.
- R2: Once the synchronized line has been low for `RST_US` µs without a break, `bus_reset` pulses high for exactly one cycle, while the line is still low. A low that ends sooner gives no pulse.
- R3: After a detected reset, once the line has risen, `pull_low` stays 0 for `PRES_GAP_US` µs and then stays 1 for `PRES_LEN_US` µs. This is the presence pulse. With the defaults (30 µs and 120 µs) it lies inside the 15–60 µs delay and 60–240 µs width windows.
- R4: A falling edge seen in idle with `tx_mode` = 0 opens a write slot. `SAMPLE_US` µs later the line level is captured, and `rx_valid` pulses for one cycle with `rx_bit` = 1 for a released line and 0 for a line still low.
- R5: A falling edge seen in idle with `tx_mode` = 1 opens a read slot. `tx_taken` pulses for one cycle. If `tx_bit` is 0, `pull_low` goes high for exactly `HOLD_US` µs (default 30, inside 17–60 µs). If `tx_bit` is 1, `pull_low` stays 0.
- R6: Each slot gives exactly one outcome, either `rx_valid` or `tx_taken`, never both. No new slot opens until the line has been seen high again.
- R7: A reset low that begins inside a slot, including a read slot whose pull-down is active, is detected exactly like one that begins in idle. `pull_low` is 0 in the cycle `bus_reset` is 1, and the presence pulse follows.
- R8: The line may stay high for any length of time between slots. Over that time no output changes, and the next slot decodes normally.
- R9: `tx_mode` and `tx_bit` are looked at only in the cycle a slot opens. Changing them later inside the slot changes neither the slot type nor the level the block puts on the line.
- R10: The presence pulse the block drives itself is not decoded as a slot: it produces neither `rx_valid` nor `tx_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Raw level of the shared data line (asynchronous) |
| pull_low | output | 1 | Pull-down enable for the open-drain driver; 1 pulls the line low |
| tx_mode | input | 1 | 1: the next slot is a read slot (slave sends) |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_taken | output | 1 | One-cycle pulse: a read slot opened and `tx_bit` was taken |
| rx_valid | output | 1 | One-cycle pulse: a write slot bit was captured |
| rx_bit | output | 1 | Captured write-slot bit, valid with `rx_valid` |
| bus_reset | output | 1 | One-cycle pulse on a detected bus reset |

## Verification
Write slots are driven with both a short strobe and a long low, so a wrong sampling point or an inverted capture shows up as a wrong bit. Read slots cover both bit values. For a 0 the bench times the pull-down width to the cycle, and for a 1 it confirms that no pull-down occurs at all. In some slots `tx_mode` or `tx_bit` changes after the edge, which separates a design that latches them at slot start from one that follows them. Resets are tried just below and just above the threshold, from idle and from inside a read slot, and the presence delay and width are timed exactly. A long idle stretch and a random mix of slot types and idle gaps check that successive slots stay independent.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_WAIT_HI,
    ST_RST_LO,
    ST_PRES_GAP,
    ST_PRES_DRV
  } slot_state_e;

  function automatic int unsigned us_to_cyc(input int unsigned us,
                                            input int unsigned per_us);
    return us * per_us;
  endfunction

endpackage

// File: rtl/slp_line_sync.sv
module slp_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_raw,
  output logic line_s
);

  logic [STAGES-1:0] chain;

  // The chain resets to the released (idle-high) level.
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], line_raw};
  end

  assign line_s = chain[STAGES-1];

endmodule

// File: rtl/slp_low_watch.sv
module slp_low_watch #(
  parameter int unsigned RST_CYC = 7680
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  output logic rst_hit
);

  localparam int unsigned CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] low_cnt;

  // Counts synchronized low cycles and saturates at the threshold, so
  // one continuous low produces a single hit.
  always_ff @(posedge clk) begin
    if (rst)                          low_cnt <= '0;
    else if (line_s)                  low_cnt <= '0;
    else if (low_cnt != CW'(RST_CYC)) low_cnt <= low_cnt + 1'b1;
  end

  assign rst_hit = !line_s && (low_cnt == CW'(RST_CYC - 1));

endmodule

// File: rtl/slp_slot_fsm.sv
module slp_slot_fsm #(
  parameter int unsigned SAMPLE_CYC = 480,
  parameter int unsigned HOLD_CYC   = 480,
  parameter int unsigned GAP_CYC    = 480,
  parameter int unsigned PRES_CYC   = 1920
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  input  logic rst_hit,
  input  logic tx_mode,
  input  logic tx_bit,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit,
  output logic tx_taken,
  output logic bus_reset
);

  import slp_pkg::*;

  localparam int unsigned M_SLOT = (SAMPLE_CYC > HOLD_CYC) ? SAMPLE_CYC : HOLD_CYC;
  localparam int unsigned M_PRES = (GAP_CYC > PRES_CYC) ? GAP_CYC : PRES_CYC;
  localparam int unsigned T_MAX  = (M_SLOT > M_PRES) ? M_SLOT : M_PRES;
  localparam int unsigned TW     = $clog2(T_MAX + 1);

  slot_state_e   state;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      tmr       <= '0;
      pull_low  <= 1'b0;
      rx_valid  <= 1'b0;
      rx_bit    <= 1'b0;
      tx_taken  <= 1'b0;
      bus_reset <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      tx_taken  <= 1'b0;
      bus_reset <= 1'b0;
      if (rst_hit) begin
        // Reset outranks whatever slot or presence phase is running.
        state     <= ST_RST_LO;
        pull_low  <= 1'b0;
        bus_reset <= 1'b1;
        tmr       <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (!line_s) begin
              tmr <= '0;
              if (tx_mode) begin
                state    <= ST_RD;
                tx_taken <= 1'b1;
                pull_low <= !tx_bit;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (tmr == TW'(SAMPLE_CYC - 1)) begin
              rx_valid <= 1'b1;
              rx_bit   <= line_s;
              state    <= ST_WAIT_HI;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_RD: begin
            if (tmr == TW'(HOLD_CYC - 1)) begin
              pull_low <= 1'b0;
              state    <= ST_WAIT_HI;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_WAIT_HI: begin
            if (line_s) state <= ST_IDLE;
          end
          ST_RST_LO: begin
            if (line_s) begin
              state <= ST_PRES_GAP;
              tmr   <= '0;
            end
          end
          ST_PRES_GAP: begin
            if (tmr == TW'(GAP_CYC - 1)) begin
              pull_low <= 1'b1;
              state    <= ST_PRES_DRV;
              tmr      <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_PRES_DRV: begin
            if (tmr == TW'(PRES_CYC - 1)) begin
              pull_low <= 1'b0;
              state    <= ST_WAIT_HI;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/single_line_slave_phy.sv
module single_line_slave_phy #(
  parameter int unsigned CLK_PER_US  = 16,
  parameter int unsigned RST_US      = 480,
  parameter int unsigned PRES_GAP_US = 30,
  parameter int unsigned PRES_LEN_US = 120,
  parameter int unsigned SAMPLE_US   = 30,
  parameter int unsigned HOLD_US     = 30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic pull_low,
  input  logic tx_mode,
  input  logic tx_bit,
  output logic tx_taken,
  output logic rx_valid,
  output logic rx_bit,
  output logic bus_reset
);

  localparam int unsigned RST_CYC    = slp_pkg::us_to_cyc(RST_US, CLK_PER_US);
  localparam int unsigned GAP_CYC    = slp_pkg::us_to_cyc(PRES_GAP_US, CLK_PER_US);
  localparam int unsigned PRES_CYC   = slp_pkg::us_to_cyc(PRES_LEN_US, CLK_PER_US);
  localparam int unsigned SAMPLE_CYC = slp_pkg::us_to_cyc(SAMPLE_US, CLK_PER_US);
  localparam int unsigned HOLD_CYC   = slp_pkg::us_to_cyc(HOLD_US, CLK_PER_US);

  logic line_s;
  logic rst_hit;

  slp_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .line_raw (line_in),
    .line_s   (line_s)
  );

  slp_low_watch #(
    .RST_CYC (RST_CYC)
  ) u_low (
    .clk     (clk),
    .rst     (rst),
    .line_s  (line_s),
    .rst_hit (rst_hit)
  );

  slp_slot_fsm #(
    .SAMPLE_CYC (SAMPLE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .GAP_CYC    (GAP_CYC),
    .PRES_CYC   (PRES_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .line_s    (line_s),
    .rst_hit   (rst_hit),
    .tx_mode   (tx_mode),
    .tx_bit    (tx_bit),
    .pull_low  (pull_low),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .tx_taken  (tx_taken),
    .bus_reset (bus_reset)
  );

endmodule

// File: rtl/slp_slave_chk.sv
module slp_slave_chk #(
  parameter int unsigned CLK_PER_US  = 16,
  parameter int unsigned PRES_LEN_US = 120,
  parameter int unsigned HOLD_US     = 30
) (
  input logic clk,
  input logic rst,
  input logic pull_low,
  input logic tx_taken,
  input logic rx_valid,
  input logic bus_reset
);

  localparam int unsigned LIM = CLK_PER_US * ((PRES_LEN_US > HOLD_US) ? PRES_LEN_US : HOLD_US);
  localparam int unsigned RW  = $clog2(LIM + 2);

  logic [RW-1:0] pull_run;
  logic          rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst || !pull_low)              pull_run <= '0;
    else if (pull_run != RW'(LIM + 1)) pull_run <= pull_run + 1'b1;
  end

  // R1: one edge after reset, all outputs are quiet.
  always @(posedge clk) begin
    if (rst_d == 1'b1)
      p_reset_quiet_r1: assert (!pull_low && !rx_valid && !tx_taken && !bus_reset)
        else $error("outputs active after reset");
  end

  p_reset_single_r2: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !bus_reset);

  p_rx_single_r4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_tx_single_r5: assert property (@(posedge clk) disable iff (rst)
    tx_taken |=> !tx_taken);

  // R3 / R5: no pull-down run longer than the longest legal one.
  p_pull_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    pull_run <= RW'(LIM));

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && tx_taken));

  p_reset_releases_r7: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> !pull_low);

  p_presence_not_slot_r10: assert property (@(posedge clk) disable iff (rst)
    bus_reset |-> (!rx_valid && !tx_taken));

endmodule

bind single_line_slave_phy slp_slave_chk #(
  .CLK_PER_US  (CLK_PER_US),
  .PRES_LEN_US (PRES_LEN_US),
  .HOLD_US     (HOLD_US)
) u_slp_chk (
  .clk       (clk),
  .rst       (rst),
  .pull_low  (pull_low),
  .tx_taken  (tx_taken),
  .rx_valid  (rx_valid),
  .bus_reset (bus_reset)
);

// File: tb/single_line_slave_phy_bench.sv
module single_line_slave_phy_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int RST_US     = 480;
  localparam int GAP_US     = 30;
  localparam int PRES_US    = 120;
  localparam int SAMPLE_US  = 30;
  localparam int HOLD_US    = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_low = 1'b0;
  logic tx_mode = 1'b0;
  logic tx_bit = 1'b1;
  logic pull_low, tx_taken, rx_valid, rx_bit, bus_reset;
  wire  line_in;

  assign line_in = ~(host_low | pull_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  single_line_slave_phy #(
    .CLK_PER_US  (CPU),
    .RST_US      (RST_US),
    .PRES_GAP_US (GAP_US),
    .PRES_LEN_US (PRES_US),
    .SAMPLE_US   (SAMPLE_US),
    .HOLD_US     (HOLD_US)
  ) u_single_line_slave_phy (
    .clk       (clk),
    .rst       (rst),
    .line_in   (line_in),
    .pull_low  (pull_low),
    .tx_mode   (tx_mode),
    .tx_bit    (tx_bit),
    .tx_taken  (tx_taken),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .bus_reset (bus_reset)
  );

  int checks = 0;
  int fails  = 0;
  int rx_cnt = 0, tx_cnt = 0, br_cnt = 0, pw_evt = 0;
  int pull_run = 0, last_pull_w = 0;
  int last_rx = 0;
  bit done = 1'b0;

  // Output monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin rx_cnt++; last_rx = int'(rx_bit); end
      if (tx_taken) tx_cnt++;
      if (bus_reset) br_cnt++;
      if (pull_low) pull_run++;
      else if (pull_run != 0) begin
        last_pull_w = pull_run;
        pull_run = 0;
        pw_evt++;
      end
    end
  end

  // Expected values from the requirements.
  function automatic int exp_write_bit(input bit b);   return int'(b); endfunction
  function automatic int exp_read_level(input bit b);  return int'(b); endfunction
  function automatic int exp_hold_cyc();  return HOLD_US * CPU; endfunction
  function automatic int exp_gap_cyc();   return GAP_US * CPU + 3; endfunction
  function automatic int exp_pres_cyc();  return PRES_US * CPU; endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(req, act == exp, act, exp);
  endtask

  task automatic wait_us(input int us);
    repeat (us * CPU) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Host write slot; optional change of tx_mode inside the slot (R9).
  task automatic write_slot(input bit b, input bit poke);
    int r0, t0;
    r0 = rx_cnt; t0 = tx_cnt;
    tx_mode = 1'b0;
    host_low = 1'b1;
    wait_us(2);
    if (b) host_low = 1'b0;
    wait_us(8);
    if (poke) tx_mode = 1'b1;
    wait_us(55);
    host_low = 1'b0;
    tx_mode = 1'b0;
    wait_us(10);
    chk_eq("R4 one rx per write slot", rx_cnt - r0, 1);
    chk_eq(poke ? "R9 write bit with tx_mode changed" : "R4 write bit", last_rx, exp_write_bit(b));
    chk_eq("R6 no tx in write slot", tx_cnt - t0, 0);
  endtask

  // Host read slot; optional change of tx_bit inside the slot (R9).
  task automatic read_slot(input bit b, input bit poke);
    int r0, t0, p0;
    logic got;
    r0 = rx_cnt; t0 = tx_cnt; p0 = pw_evt;
    tx_mode = 1'b1;
    tx_bit = b;
    host_low = 1'b1;
    wait_us(2);
    host_low = 1'b0;
    wait_us(3);
    if (poke) tx_bit = ~b;
    wait_us(10);
    got = line_in;
    wait_us(45);
    tx_mode = 1'b0;
    wait_us(15);
    chk_eq("R5 one tx_taken per read slot", tx_cnt - t0, 1);
    chk_eq(poke ? "R9 read level with tx_bit changed" : "R5 read level", int'(got), exp_read_level(b));
    chk_eq("R6 no rx in read slot", rx_cnt - r0, 0);
    chk_eq("R5 pull-down events", pw_evt - p0, b ? 0 : 1);
    if (!b) chk_eq("R5 pull-down width cycles", last_pull_w, exp_hold_cyc());
  endtask

  // Long low; mode selects a slot type at the edge (R7 when 1).
  task automatic long_low(input int low_us, input bit expect_rst, input bit mode);
    int b0, t0, r_mid, gap, width;
    b0 = br_cnt; t0 = tx_cnt;
    tx_mode = mode;
    tx_bit = 1'b0;
    host_low = 1'b1;
    wait_us(low_us);
    host_low = 1'b0;
    tx_mode = 1'b0;
    r_mid = rx_cnt;
    gap = 0;
    while (!pull_low && gap < 100 * CPU) begin @(negedge clk); gap++; end
    width = 0;
    while (pull_low && width < 300 * CPU) begin @(negedge clk); width++; end
    wait_us(20);
    if (expect_rst) begin
      chk_eq(mode ? "R7 reset inside read slot" : "R2 reset pulse count", br_cnt - b0, 1);
      check("R3 presence delay cycles", (gap >= exp_gap_cyc() - 1) && (gap <= exp_gap_cyc() + 1),
            gap, exp_gap_cyc());
      chk_eq("R3 presence width cycles", width, exp_pres_cyc());
      chk_eq("R10 presence gives no rx", rx_cnt - r_mid, 0);
      chk_eq("R10 presence gives no extra tx", tx_cnt - t0, int'(mode));
    end else begin
      chk_eq("R2 short low gives no reset", br_cnt - b0, 0);
      chk_eq("R2 short low gives no presence", gap, 100 * CPU);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed_set;
    int c0, r0, t0, b0, p0;
    seed_set = $urandom(32'h5EED_1A2B);

    repeat (5) @(negedge clk);
    chk_eq("R1 pull_low in reset", int'(pull_low), 0);
    chk_eq("R1 strobes in reset", int'(rx_valid | tx_taken | bus_reset), 0);
    rst = 1'b0;
    wait_us(5);

    long_low(500, 1'b1, 1'b0);
    long_low(476, 1'b0, 1'b0);
    long_low(484, 1'b1, 1'b0);

    write_slot(1'b0, 1'b0);
    write_slot(1'b1, 1'b0);
    read_slot(1'b0, 1'b0);
    read_slot(1'b1, 1'b0);
    read_slot(1'b0, 1'b1);
    read_slot(1'b1, 1'b1);
    write_slot(1'b1, 1'b1);
    write_slot(1'b0, 1'b1);

    // R8: long idle, then normal slots.
    r0 = rx_cnt; t0 = tx_cnt; b0 = br_cnt; p0 = pw_evt; c0 = 0;
    for (int i = 0; i < 3000 * CPU; i++) begin
      @(negedge clk);
      if (pull_low) c0++;
    end
    chk_eq("R8 idle leaves outputs quiet", (rx_cnt - r0) + (tx_cnt - t0) + (br_cnt - b0) + (pw_evt - p0) + c0, 0);
    write_slot(1'b0, 1'b0);
    read_slot(1'b0, 1'b0);

    long_low(500, 1'b1, 1'b1);
    read_slot(1'b1, 1'b0);

    for (int i = 0; i < 60; i++) begin
      bit kind, b;
      int gap;
      kind = 1'($urandom_range(0, 1));
      b    = 1'($urandom_range(0, 1));
      gap  = int'($urandom_range(0, 150));
      if (kind) read_slot(b, 1'b0);
      else      write_slot(b, 1'b0);
      wait_us(gap);
    end

    long_low(490, 1'b1, 1'b0);
    write_slot(1'b1, 1'b0);

    summary();
  end

endmodule